// File: doc/BRIEF.md
# Dummy-Fetch Bus Access Sequencer

This block sits between an instruction-fetch unit and an external program memory. It makes real code fetches hard to pick out on the bus. Every instruction cycle puts two read slots on the bus. When obfuscation is active, one slot carries the address the core asked for. The other slot carries a pseudo-random address, and the memory really is read there. A repeatable pseudo-random bit decides whether the real slot comes first or second. The bytes read in the dummy slot are dropped inside the block. The core only ever sees the byte from the real slot. That byte is handed over at a fixed point after both slots, so the order cannot be read from the core-side timing.

The core holds its request and address steady. The block samples them at the end of the clock in which `fetch_ack_o` is high. The result comes back as a one-clock `fetch_valid_o` pulse at the start of the following instruction cycle. A mode input makes dummy insertion unconditional. Otherwise dummy insertion follows the encryption-enable input. Without obfuscation, both slots read the requested address. The block is read-only toward memory and has no write strobe.

Top module: `shfetch_seq`

## Requirements
- R1: While reset is high, `bus_ale_o`, `bus_ce_o`, `bus_addr_o`, `fetch_valid_o`, `fetch_data_o` and `fetch_ack_o` are all zero. The pseudo-random state is loaded with 16'hACE1.
- R2: An instruction cycle lasts four clocks, split into two slots of two clocks each. `bus_ale_o` is high only in the first clock of a slot. `bus_ce_o` is high for all four clocks of an active cycle. `bus_addr_o` holds its value for both clocks of a slot.
- R3: The pseudo-random state is a 16-bit right-shifting Galois LFSR with tap mask 16'hB400. It steps once per instruction cycle, on the sampling edge. The stepped state supplies the order bit from bit 0 and the dummy address from bits 15:1.
- R4: Obfuscated with a request: order bit 0 puts the real address in slot 0 and the dummy address in slot 1. Order bit 1 swaps them. Across a run, both orders occur.
- R5: Obfuscation is active when `dummy_always_i` or `crypt_en_i` is 1. It is inactive only when both are 0.
- R6: Not obfuscated with a request: both slots carry the requested address.
- R7: No request and obfuscated: slot 0 carries the dummy address and slot 1 carries its bitwise inverse. No request and not obfuscated: the cycle is idle, with `bus_ce_o`, `bus_ale_o` and `bus_addr_o` all 0.
- R8: For a request, `fetch_valid_o` is high for exactly the first clock of the next instruction cycle. At that point `fetch_data_o` holds the byte read at the real address, whatever the order.
- R9: `fetch_data_o` changes only together with a `fetch_valid_o` pulse. Dummy bytes and cycles without a request leave it unchanged.
- R10: A new reset restarts the same pseudo-random sequence. The same stimulus then yields the same bus addresses.
- R11: `fetch_ack_o` is high for one clock, in the last clock of each cycle (the second clock after reset release for the first cycle). The request and mode inputs are sampled at the end of that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req_i | input | 1 | Core wants a fetch this cycle |
| fetch_addr_i | input | ADDR_W | Real fetch address |
| dummy_always_i | input | 1 | Always insert dummy slots |
| crypt_en_i | input | 1 | Encryption enabled; enables dummy slots |
| fetch_ack_o | output | 1 | Inputs sampled at end of this clock |
| fetch_valid_o | output | 1 | One-clock pulse: fetch_data_o is new |
| fetch_data_o | output | DATA_W | Byte from the real slot |
| bus_ale_o | output | 1 | Address strobe, one clock per slot |
| bus_ce_o | output | 1 | Memory chip enable |
| bus_addr_o | output | ADDR_W | Memory read address |
| bus_rdata_i | input | DATA_W | Memory read data |

## Verification
The bench modelling the memory returns a byte computed from the address, so a byte from the wrong slot is caught at once.

The sweep runs every combination of the two mode inputs, with and without a request, over stepping addresses. This separates the obfuscated paths from the plain path, and the idle cycle from the all-dummy cycle. The obfuscated cycles with a request are counted by order bit, which shows that both slot positions of the real fetch are exercised. A second reset replays the first cycles and compares the slot addresses with those recorded the first time.

// File: rtl/shfetch_pkg.sv
package shfetch_pkg;
  typedef enum logic [1:0] {
    PH_A0 = 2'd0,
    PH_A1 = 2'd1,
    PH_B0 = 2'd2,
    PH_B1 = 2'd3
  } phase_e;
endpackage

// File: rtl/shfetch_lfsr.sv
module shfetch_lfsr #(
  parameter int          W    = 16,
  parameter logic [15:0] TAPS = 16'hB400,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_i,
  output logic [W-1:0] next_o
);
  logic [W-1:0] state_q;

  // Galois right shift: bit 0 leaves and is folded back in through the taps.
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == W-1) begin : g_top
      assign next_o[i] = TAPS[i] & state_q[0];
    end else begin : g_mid
      assign next_o[i] = state_q[i+1] ^ (TAPS[i] & state_q[0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         state_q <= SEED[W-1:0];
    else if (step_i) state_q <= next_o;
  end
endmodule

// File: rtl/shfetch_plan.sv
module shfetch_plan #(
  parameter int ADDR_W = 15
) (
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              obf_i,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] dummy_i,
  output logic              active_o,
  output logic              real2_o,
  output logic [ADDR_W-1:0] slot0_o,
  output logic [ADDR_W-1:0] slot1_o
);
  always_comb begin
    if (obf_i) begin
      active_o = 1'b1;
      if (req_i) begin
        real2_o = order_i;
        slot0_o = order_i ? dummy_i : addr_i;
        slot1_o = order_i ? addr_i : dummy_i;
      end else begin
        real2_o = 1'b0;
        slot0_o = dummy_i;
        slot1_o = ~dummy_i;
      end
    end else begin
      active_o = req_i;
      real2_o  = 1'b1;
      slot0_o  = req_i ? addr_i : '0;
      slot1_o  = req_i ? addr_i : '0;
    end
  end
endmodule

// File: rtl/shfetch_capture.sv
module shfetch_capture #(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  shfetch_pkg::phase_e phase_i,
  input  logic                req_i,
  input  logic                real2_i,
  input  logic [DATA_W-1:0]   rdata_i,
  output logic                valid_o,
  output logic [DATA_W-1:0]   data_o
);
  import shfetch_pkg::*;
  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= 1'b0;
      if (phase_i == PH_A1 && !real2_i) hold_q <= rdata_i;
      if (phase_i == PH_B1 && req_i) begin
        valid_o <= 1'b1;
        data_o  <= real2_i ? rdata_i : hold_q;
      end
    end
  end
endmodule

// File: rtl/shfetch_seq.sv
module shfetch_seq #(
  parameter int          ADDR_W    = 15,
  parameter int          DATA_W    = 8,
  parameter int          LFSR_W    = 16,
  parameter logic [15:0] LFSR_TAPS = 16'hB400,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_req_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              dummy_always_i,
  input  logic              crypt_en_i,
  output logic              fetch_ack_o,
  output logic              fetch_valid_o,
  output logic [DATA_W-1:0] fetch_data_o,
  output logic              bus_ale_o,
  output logic              bus_ce_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  input  logic [DATA_W-1:0] bus_rdata_i
);
  import shfetch_pkg::*;

  localparam int DUMMY_HI = ADDR_W;

  phase_e            phase_q;
  logic              latch;
  logic [LFSR_W-1:0] lfsr_nx;
  logic              obf;
  logic              p_active, p_real2;
  logic [ADDR_W-1:0] p_slot0, p_slot1;
  logic [ADDR_W-1:0] slot1_q;
  logic              active_q, req_q, real2_q;

  assign latch = (phase_q == PH_B1);
  assign obf   = dummy_always_i | crypt_en_i;

  shfetch_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst(rst), .step_i(latch), .next_o(lfsr_nx)
  );

  shfetch_plan #(.ADDR_W(ADDR_W)) u_plan (
    .req_i(fetch_req_i), .addr_i(fetch_addr_i), .obf_i(obf),
    .order_i(lfsr_nx[0]), .dummy_i(lfsr_nx[DUMMY_HI:1]),
    .active_o(p_active), .real2_o(p_real2),
    .slot0_o(p_slot0), .slot1_o(p_slot1)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= PH_B0;
      fetch_ack_o <= 1'b0;
      bus_ale_o   <= 1'b0;
      bus_ce_o    <= 1'b0;
      bus_addr_o  <= '0;
      slot1_q     <= '0;
      active_q    <= 1'b0;
      req_q       <= 1'b0;
      real2_q     <= 1'b0;
    end else begin
      fetch_ack_o <= (phase_q == PH_B0);
      case (phase_q)
        PH_B1: begin
          phase_q    <= PH_A0;
          req_q      <= fetch_req_i;
          real2_q    <= p_real2;
          active_q   <= p_active;
          slot1_q    <= p_slot1;
          bus_ce_o   <= p_active;
          bus_ale_o  <= p_active;
          bus_addr_o <= p_slot0;
        end
        PH_A0: begin
          phase_q   <= PH_A1;
          bus_ale_o <= 1'b0;
        end
        PH_A1: begin
          phase_q    <= PH_B0;
          bus_ale_o  <= active_q;
          bus_addr_o <= slot1_q;
        end
        default: begin
          phase_q   <= PH_B1;
          bus_ale_o <= 1'b0;
        end
      endcase
    end
  end

  shfetch_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .phase_i(phase_q), .req_i(req_q),
    .real2_i(real2_q), .rdata_i(bus_rdata_i),
    .valid_o(fetch_valid_o), .data_o(fetch_data_o)
  );
endmodule

// File: rtl/shfetch_seq_chk.sv
module shfetch_seq_chk #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_ale_o,
  input logic              bus_ce_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              fetch_ack_o,
  input logic              fetch_valid_o,
  input logic [DATA_W-1:0] fetch_data_o
);
  // R2
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    bus_ale_o |=> !bus_ale_o);
  // R2
  strobe_in_enable_chk: assert property (@(posedge clk) disable iff (rst)
    bus_ale_o |-> bus_ce_o);
  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_ce_o && !bus_ale_o) |-> $stable(bus_addr_o));
  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_valid_o |=> !fetch_valid_o);
  // R9
  data_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid_o |-> $stable(fetch_data_o));
  // R11
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_ack_o |=> !fetch_ack_o);
  // R11
  valid_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_valid_o |-> $past(fetch_ack_o));
endmodule

bind shfetch_seq shfetch_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_ale_o(bus_ale_o), .bus_ce_o(bus_ce_o),
  .bus_addr_o(bus_addr_o), .fetch_ack_o(fetch_ack_o),
  .fetch_valid_o(fetch_valid_o), .fetch_data_o(fetch_data_o)
);

// File: tb/shfetch_seq_tb.sv
module shfetch_seq_tb;
  localparam int AW = 15;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic [AW-1:0] addr = '0;
  logic alw = 1'b0, enc = 1'b0;
  logic ack, valid, ale, ce;
  logic [DW-1:0] data, rdata;
  logic [AW-1:0] baddr;

  always #2 clk = ~clk;

  function automatic logic [DW-1:0] mem_f(input logic [AW-1:0] a);
    return a[7:0] ^ {a[14:8], a[0]};
  endfunction
  assign rdata = mem_f(baddr);

  shfetch_seq u_dut (
    .clk(clk), .rst(rst), .fetch_req_i(req), .fetch_addr_i(addr),
    .dummy_always_i(alw), .crypt_en_i(enc), .fetch_ack_o(ack),
    .fetch_valid_o(valid), .fetch_data_o(data), .bus_ale_o(ale),
    .bus_ce_o(ce), .bus_addr_o(baddr), .bus_rdata_i(rdata)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [15:0] s;
  logic prev_req;
  logic [AW-1:0] prev_addr;
  logic [DW-1:0] last_data;
  int ord0 = 0, ord1 = 0;
  logic [AW-1:0] rec0 [16];
  logic [AW-1:0] rec1 [16];

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 ale", ale, 0); chk("R1 ce", ce, 0); chk("R1 addr", baddr, 0);
    chk("R1 valid", valid, 0); chk("R1 data", data, 0); chk("R1 ack", ack, 0);
    rst = 1'b0;
    s = 16'hACE1; prev_req = 1'b0; last_data = '0;
    @(negedge clk);
    chk("R11 first ack", ack, 1);
  endtask

  task automatic run_cycle(input logic rq, input logic [AW-1:0] ad,
                           input logic a, input logic e, input int rec_idx,
                           input bit second);
    logic obf, act;
    logic [AW-1:0] dm, s0, s1;
    req = rq; addr = ad; alw = a; enc = e;
    s = {1'b0, s[15:1]} ^ (s[0] ? 16'hB400 : 16'h0);  // R3
    dm = s[15:1];
    obf = a | e;  // R5
    act = obf | rq;
    if (obf && rq) begin  // R4
      s0 = s[0] ? dm : ad; s1 = s[0] ? ad : dm;
      if (s[0]) ord1++; else ord0++;
    end else if (obf) begin  // R7
      s0 = dm; s1 = ~dm;
    end else if (rq) begin  // R6
      s0 = ad; s1 = ad;
    end else begin
      s0 = '0; s1 = '0;
    end
    @(posedge clk);
    for (int p = 0; p < 4; p++) begin
      @(negedge clk);
      if (p == 0) begin
        if (prev_req) last_data = mem_f(prev_addr);
        chk("R8 valid", valid, prev_req);
        chk("R8 data", data, last_data);
        if (rec_idx < 16) begin
          if (second) rec1[rec_idx] = baddr; else rec0[rec_idx] = baddr;
        end
      end else begin
        chk("R9 no valid", valid, 0);
        chk("R9 data held", data, last_data);
      end
      chk("R2 ale", ale, ((p == 0 || p == 2) && act) ? 1 : 0);
      chk("R7 R2 ce", ce, act);
      chk("R4 R6 R7 addr", baddr, (p < 2) ? s0 : s1);
      chk("R11 ack", ack, (p == 3) ? 1 : 0);
    end
    prev_req = rq; prev_addr = ad;
  endtask

  initial begin
    #300000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    for (int k = 0; k < 96; k++) begin
      logic [AW-1:0] ad;
      ad = AW'(k * 16'h1357 + 3);
      run_cycle(k[2] | k[3], ad, k[0], k[1], k, 1'b0);
    end
    run_cycle(1'b0, '0, 1'b0, 1'b0, 99, 1'b0);
    chk("R4 order0 seen", (ord0 > 0) ? 1 : 0, 1);
    chk("R4 order1 seen", (ord1 > 0) ? 1 : 0, 1);
    // R10: replay after a new reset
    do_reset();
    for (int k = 0; k < 16; k++) begin
      logic [AW-1:0] ad;
      ad = AW'(k * 16'h1357 + 3);
      run_cycle(k[2] | k[3], ad, k[0], k[1], k, 1'b1);
    end
    for (int k = 0; k < 16; k++) chk("R10 replay", rec1[k], rec0[k]);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule